// File: doc/BRIEF.md
# Multi-channel DMA termination controller

This block holds the channel state and stop logic of a multi-channel DMA engine. Each channel has a source address, a destination address, a transfer count and a control word. The control word holds enable, interrupt-enable, end-of-transfer, unit size and address stepping mode. One global word holds a master enable, a sticky NMI flag and a sticky address-error flag. Transfers are abstract. A fixed-priority arbiter grants one channel at a time. The agent that moves the data then answers with either a done pulse or an error pulse.

Stopping happens on two separate paths. A single channel stops normally when its count reaches zero, which sets its end flag and may raise its interrupt. It also stops when software clears its enable bit, and in that case no end flag is set. All channels stop together on an NMI, on an address error, or when the master enable is cleared. After such a global stop, every register reflects the last transfer that completed. If that transfer was a channel's final one, the channel's end flag is still set.

Registers are reached through a word-addressed port. The write is synchronous and the read is combinational. Address bit ADDR_W-1 selects the global word. Below that bit, the next CH_W bits select the channel, and bits [1:0] select the field: 0 source, 1 destination, 2 count, 3 control. Control bits: [0] enable, [1] interrupt enable, [2] end flag, [4:3] unit size (0=1, 1=2, 2=4, 3=16 bytes), [6:5] source mode, [8:7] destination mode. Mode values are 1 for increment, 2 for decrement, and 0 or 3 for fixed. Global bits: [0] master enable, [1] NMI flag, [2] address-error flag.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset all channel registers, the global word, grant_o and irq_o read zero.
- R2: An accepted done pulse (xfer_done_i with the channel granted and xfer_err_i low) lowers that channel's count by exactly one for every unit size. It also steps the source and destination addresses by the unit size (1, 2, 4 or 16 bytes) according to each address's mode: up, down, or fixed.
- R3: An accepted done that takes the count from 1 to 0 sets the channel's end flag (control bit 2). The channel then gets no further grant.
- R4: irq_o[i] is high exactly while channel i has both its end flag and its interrupt-enable bit set.
- R5: Once a write has cleared a channel's enable bit, that channel's grant drops and a done pulse has no effect on it. Its end flag stays 0.
- R6: A pulse on nmi_i sets the NMI flag (global bit 1), and from the next cycle no channel holds a grant. Every channel's registers keep their values.
- R7: While the master enable (global bit 0) is 0, no channel is granted. Setting it lets pending requests proceed.
- R8: xfer_err_i on a granted transfer sets the address-error flag (global bit 2) in that cycle and stops all channels. The faulting channel's addresses and count do not change.
- R9: A done accepted in the same cycle that an NMI arrives still updates the channel. If it was the final transfer, it sets the end flag.
- R10: The end, NMI and address-error flags are sticky. Writing 1 to them has no effect, writing 0 clears them, and after clearing the channels become eligible again.
- R11: Among channels with enable=1, end flag=0, count≠0 and a request, and with no global stop active, the lowest index is granted. That grant is held until done or error.
- R12: At most one grant is high. While a grant is high, xfer_src_o, xfer_dst_o and xfer_unit_o show the granted channel's source, destination and unit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| nmi_i | input | 1 | Non-maskable interrupt event |
| req_i | input | NCH | Per-channel transfer request |
| grant_o | output | NCH | One-hot transfer grant |
| xfer_src_o | output | AW | Source address of granted channel |
| xfer_dst_o | output | AW | Destination address of granted channel |
| xfer_unit_o | output | 2 | Unit size code of granted channel |
| xfer_done_i | input | 1 | Granted transfer completed |
| xfer_err_i | input | 1 | Granted transfer faulted (address error) |
| irq_o | output | NCH | Per-channel end-of-transfer interrupt |

## Verification
The bench builds the block with its defaults: four channels, 32-bit addresses and a 16-bit count. Four channels are enough to show the priority between two and three simultaneous requesters. They also show a global stop affecting channels other than the one that caused it. The 32-bit address width lets the 16-byte stepping and the decrement wrap be observed without truncation.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    US_1B  = 2'd0,
    US_2B  = 2'd1,
    US_4B  = 2'd2,
    US_16B = 2'd3
  } unit_e;

  localparam logic [1:0] AM_INC = 2'd1;
  localparam logic [1:0] AM_DEC = 2'd2;

  typedef struct packed {
    logic [1:0] dst_mode;
    logic [1:0] src_mode;
    unit_e      unit;
    logic       te;
    logic       ie;
    logic       de;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] F_SAR  = 2'd0;
  localparam logic [1:0] F_DAR  = 2'd1;
  localparam logic [1:0] F_TCR  = 2'd2;
  localparam logic [1:0] F_CTRL = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_term_pkg::*;
#(
  parameter int AW    = 32,
  parameter int TCR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       field_i,
  input  logic [31:0]      wdata_i,
  input  logic             xfer_ok_i,
  output logic [AW-1:0]    sar_o,
  output logic [AW-1:0]    dar_o,
  output logic [TCR_W-1:0] tcr_o,
  output ctrl_t            ctrl_o
);
  logic [AW-1:0] ubytes, sar_nxt, dar_nxt;
  logic          last_xfer;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [AW-1:0] inc);
    case (m)
      AM_INC:  step = a + inc;
      AM_DEC:  step = a - inc;
      default: step = a;
    endcase
  endfunction

  always_comb begin
    case (ctrl_o.unit)
      US_1B:   ubytes = AW'(1);
      US_2B:   ubytes = AW'(2);
      US_4B:   ubytes = AW'(4);
      default: ubytes = AW'(16);
    endcase
  end

  assign sar_nxt   = step(sar_o, ctrl_o.src_mode, ubytes);
  assign dar_nxt   = step(dar_o, ctrl_o.dst_mode, ubytes);
  assign last_xfer = (tcr_o == TCR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_o  <= '0;
      dar_o  <= '0;
      tcr_o  <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_i && field_i == F_SAR) sar_o <= wdata_i[AW-1:0];
      else if (xfer_ok_i)           sar_o <= sar_nxt;

      if (wr_i && field_i == F_DAR) dar_o <= wdata_i[AW-1:0];
      else if (xfer_ok_i)           dar_o <= dar_nxt;

      if (wr_i && field_i == F_TCR) tcr_o <= wdata_i[TCR_W-1:0];
      else if (xfer_ok_i)           tcr_o <= tcr_o - TCR_W'(1);

      if (wr_i && field_i == F_CTRL) begin
        ctrl_o.de       <= wdata_i[0];
        ctrl_o.ie       <= wdata_i[1];
        ctrl_o.te       <= ctrl_o.te & wdata_i[2];  // write-0-to-clear
        ctrl_o.unit     <= unit_e'(wdata_i[4:3]);
        ctrl_o.src_mode <= wdata_i[6:5];
        ctrl_o.dst_mode <= wdata_i[8:7];
      end
      if (xfer_ok_i && last_xfer) ctrl_o.te <= 1'b1;  // set wins over clear
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] active_i,
  input  logic           done_i,
  input  logic           err_i,
  output logic [NCH-1:0] grant_o
);
  logic            busy_q, found;
  logic [CH_W-1:0] cur_q, pick;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (elig_i[i] && !found) begin
        pick  = CH_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (busy_q && active_i[cur_q]) grant_o[cur_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (busy_q) begin
      if (!active_i[cur_q] || done_i || err_i) busy_q <= 1'b0;
    end else if (found) begin
      busy_q <= 1'b1;
      cur_q  <= pick;
    end
  end
endmodule

// File: rtl/dma_glob_reg.sv
module dma_glob_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       nmi_i,
  input  logic       aerr_i,
  output logic       dme_o,
  output logic       nmif_o,
  output logic       ae_o,
  output logic       suspend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dme_o  <= 1'b0;
      nmif_o <= 1'b0;
      ae_o   <= 1'b0;
    end else begin
      if (wr_i) dme_o <= wdata_i[0];
      nmif_o <= nmi_i  | (nmif_o & (~wr_i | wdata_i[1]));
      ae_o   <= aerr_i | (ae_o   & (~wr_i | wdata_i[2]));
    end
  end

  assign suspend_o = ~dme_o | nmif_o | ae_o;
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int TCR_W = 16,
  localparam int CH_W   = $clog2(NCH),
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              nmi_i,
  input  logic [NCH-1:0]    req_i,
  output logic [NCH-1:0]    grant_o,
  output logic [AW-1:0]     xfer_src_o,
  output logic [AW-1:0]     xfer_dst_o,
  output logic [1:0]        xfer_unit_o,
  input  logic              xfer_done_i,
  input  logic              xfer_err_i,
  output logic [NCH-1:0]    irq_o
);
  logic            glob_sel;
  logic [CH_W-1:0] ch_sel;
  logic [1:0]      field;
  logic            dme, nmif, ae, suspend, aerr;

  logic [AW-1:0]    sar_q [NCH];
  logic [AW-1:0]    dar_q [NCH];
  logic [TCR_W-1:0] tcr_q [NCH];
  ctrl_t            ctrl_q [NCH];
  logic [NCH-1:0]   active, elig, xfer_ok, te_vec, de_vec;

  assign glob_sel = reg_addr_i[ADDR_W-1];
  assign ch_sel   = reg_addr_i[ADDR_W-2 -: CH_W];
  assign field    = reg_addr_i[1:0];
  assign aerr     = (|grant_o) & xfer_err_i;

  dma_glob_reg u_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i & glob_sel),
    .wdata_i   (reg_wdata_i[2:0]),
    .nmi_i     (nmi_i),
    .aerr_i    (aerr),
    .dme_o     (dme),
    .nmif_o    (nmif),
    .ae_o      (ae),
    .suspend_o (suspend)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_regs #(.AW(AW), .TCR_W(TCR_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_wr_i && !glob_sel && ch_sel == CH_W'(i)),
      .field_i   (field),
      .wdata_i   (reg_wdata_i),
      .xfer_ok_i (xfer_ok[i]),
      .sar_o     (sar_q[i]),
      .dar_o     (dar_q[i]),
      .tcr_o     (tcr_q[i]),
      .ctrl_o    (ctrl_q[i])
    );
    assign te_vec[i]  = ctrl_q[i].te;
    assign de_vec[i]  = ctrl_q[i].de;
    assign active[i]  = ctrl_q[i].de & ~ctrl_q[i].te & (tcr_q[i] != '0) & ~suspend;
    assign elig[i]    = active[i] & req_i[i];
    assign xfer_ok[i] = grant_o[i] & xfer_done_i & ~xfer_err_i;
    assign irq_o[i]   = ctrl_q[i].te & ctrl_q[i].ie;
  end

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .elig_i   (elig),
    .active_i (active),
    .done_i   (xfer_done_i),
    .err_i    (xfer_err_i),
    .grant_o  (grant_o)
  );

  always_comb begin
    xfer_src_o  = '0;
    xfer_dst_o  = '0;
    xfer_unit_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant_o[i]) begin
        xfer_src_o  = sar_q[i];
        xfer_dst_o  = dar_q[i];
        xfer_unit_o = ctrl_q[i].unit;
      end
    end
  end

  always_comb begin
    if (glob_sel) reg_rdata_o = {29'd0, ae, nmif, dme};
    else begin
      case (field)
        F_SAR:   reg_rdata_o = 32'(sar_q[ch_sel]);
        F_DAR:   reg_rdata_o = 32'(dar_q[ch_sel]);
        F_TCR:   reg_rdata_o = 32'(tcr_q[ch_sel]);
        default: reg_rdata_o = 32'(ctrl_q[ch_sel]);
      endcase
    end
  end
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] grant_o,
  input logic           xfer_done_i,
  input logic           xfer_err_i,
  input logic           nmi_i,
  input logic           suspend,
  input logic [NCH-1:0] te_vec,
  input logic [NCH-1:0] de_vec
);
  assert_onehot_grant_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_nmi_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> (grant_o == '0));

  assert_err_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && xfer_err_i) |=> (grant_o == '0));

  assert_suspend_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend |-> (grant_o == '0));

  assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && (xfer_done_i || xfer_err_i)) |=> (grant_o == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_te_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(te_vec[i]) |-> $past(grant_o[i] && xfer_done_i && !xfer_err_i));

    assert_de_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !de_vec[i] |-> !grant_o[i]);
  end
endmodule

bind dma_term_ctrl dma_term_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_o     (grant_o),
  .xfer_done_i (xfer_done_i),
  .xfer_err_i  (xfer_err_i),
  .nmi_i       (nmi_i),
  .suspend     (suspend),
  .te_vec      (te_vec),
  .de_vec      (de_vec)
);

// File: tb/tb_dma_term_ctrl.sv
`timescale 1ns/1ps
module tb_dma_term_ctrl;
  localparam int NCH = 4;
  localparam int AW = 32;
  localparam int GLOB = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi = 1'b0;
  logic [3:0]  req = '0;
  logic [3:0]  grant;
  logic [31:0] xsrc, xdst;
  logic [1:0]  xunit;
  logic        done = 1'b0;
  logic        err = 1'b0;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_term_ctrl #(.NCH(NCH), .AW(AW), .TCR_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .nmi_i(nmi), .req_i(req),
    .grant_o(grant), .xfer_src_o(xsrc), .xfer_dst_o(xdst), .xfer_unit_o(xunit),
    .xfer_done_i(done), .xfer_err_i(err), .irq_o(irq)
  );

  // unit, src mode, dst mode, expected source delta, expected destination delta
  localparam int V_N = 8;
  localparam int V_UNIT[V_N] = '{0, 1, 2, 3, 3, 2, 1, 0};
  localparam int V_SM[V_N]   = '{1, 1, 2, 1, 0, 1, 2, 3};
  localparam int V_DM[V_N]   = '{2, 1, 0, 2, 1, 1, 2, 1};
  localparam int V_DS[V_N]   = '{1, 2, -4, 16, 0, 4, -2, 0};
  localparam int V_DD[V_N]   = '{-1, 2, 0, -16, 16, 4, -2, 1};

  function automatic int a_of(int ch, int f);
    return ch * 4 + f;
  endfunction

  function automatic logic [31:0] cw(int de, int ie, int te, int u, int sm, int dm);
    return 32'(de | (ie << 1) | (te << 2) | (u << 3) | (sm << 5) | (dm << 7));
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_grant(int ch, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 8 && !ok; k++) begin
      @(negedge clk);
      if (grant[ch]) ok = 1'b1;
    end
  endtask

  // request, wait for grant, answer with done or error
  task automatic xfer(int ch, bit with_err, string r);
    bit ok;
    req[ch] = 1'b1;
    wait_grant(ch, ok);
    check(r, 32'(ok), 32'd1);
    if (with_err) err = 1'b1; else done = 1'b1;
    @(negedge clk);
    done = 1'b0; err = 1'b0; req = '0;
  endtask

  task automatic setup(int ch, logic [31:0] s, logic [31:0] d, logic [31:0] n, logic [31:0] c);
    wr(a_of(ch, 0), s); wr(a_of(ch, 1), d); wr(a_of(ch, 2), n); wr(a_of(ch, 3), c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(a_of(0, 3), v); check("R1 ctrl", v, 0);
    rd(a_of(2, 0), v); check("R1 sar", v, 0);
    rd(GLOB, v);       check("R1 glob", v, 0);
    check("R1 grant", 32'(grant), 0);
    check("R1 irq", 32'(irq), 0);

    // R7: master enable off blocks grants
    setup(0, 32'h100, 32'h200, 2, cw(1, 0, 0, 0, 1, 1));
    req[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 no grant without master enable", 32'(grant), 0);
    wr(GLOB, 1);
    wait_grant(0, ok);
    check("R7 grant after master enable", 32'(ok), 1);
    // R12: transfer outputs follow the granted channel
    check("R12 src", xsrc, 32'h100);
    check("R12 dst", xdst, 32'h200);
    check("R12 unit", 32'(xunit), 0);
    done = 1'b1; @(negedge clk); done = 1'b0; req = '0;

    // R2: stepping table
    for (int k = 0; k < V_N; k++) begin
      setup(0, 32'h1000, 32'h2000, 5, cw(1, 0, 0, V_UNIT[k], V_SM[k], V_DM[k]));
      xfer(0, 1'b0, "R2 grant");
      rd(a_of(0, 0), v); check("R2 sar", v, 32'(32'h1000 + V_DS[k]));
      rd(a_of(0, 1), v); check("R2 dar", v, 32'(32'h2000 + V_DD[k]));
      rd(a_of(0, 2), v); check("R2 tcr", v, 4);
    end
    wr(a_of(0, 3), 0);

    // R3, R4: final transfer sets end flag and interrupt
    setup(1, 32'h40, 32'h80, 1, cw(1, 1, 0, 2, 1, 1));
    xfer(1, 1'b0, "R3 grant");
    rd(a_of(1, 2), v); check("R3 tcr zero", v, 0);
    rd(a_of(1, 3), v); check("R3 end flag", v & 32'h4, 32'h4);
    check("R4 irq", 32'(irq), 32'h2);
    req[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 no grant after end", 32'(grant), 0);
    req = '0;
    // R10: end flag sticky
    wr(a_of(1, 3), cw(1, 1, 1, 2, 1, 1));
    rd(a_of(1, 3), v); check("R10 write 1 keeps end flag", v & 32'h4, 32'h4);
    wr(a_of(1, 2), 2);
    wr(a_of(1, 3), cw(1, 1, 0, 2, 1, 1));
    rd(a_of(1, 3), v); check("R10 write 0 clears end flag", v & 32'h4, 0);
    check("R4 irq cleared", 32'(irq), 0);
    xfer(1, 1'b0, "R10 channel resumes");

    // R11: fixed priority
    setup(2, 32'h300, 32'h400, 3, cw(1, 0, 0, 0, 1, 1));
    setup(3, 32'h500, 32'h600, 3, cw(1, 0, 0, 0, 1, 1));
    req = 4'b1110;
    wait_grant(1, ok);
    check("R11 lowest index wins", 32'(grant), 32'h2);
    repeat (2) @(negedge clk);
    check("R11 grant held", 32'(grant), 32'h2);
    done = 1'b1; @(negedge clk); done = 1'b0; req[1] = 1'b0;
    wait_grant(2, ok);
    check("R11 next channel", 32'(grant), 32'h4);
    done = 1'b1; @(negedge clk); done = 1'b0; req = '0;

    // R5: enable clear halts without end flag
    setup(0, 32'h10, 32'h20, 5, cw(1, 1, 0, 0, 1, 1));
    req[0] = 1'b1;
    wait_grant(0, ok);
    wr(a_of(0, 3), cw(0, 1, 0, 0, 1, 1));
    check("R5 grant dropped", 32'(grant), 0);
    done = 1'b1; @(negedge clk); done = 1'b0; req = '0;
    rd(a_of(0, 2), v); check("R5 tcr unchanged", v, 5);
    rd(a_of(0, 3), v); check("R5 no end flag", v & 32'h4, 0);

    // R6, R9: NMI together with final done
    setup(0, 32'h10, 32'h20, 1, cw(1, 0, 0, 0, 1, 1));
    req[0] = 1'b1;
    wait_grant(0, ok);
    done = 1'b1; nmi = 1'b1;
    @(negedge clk);
    done = 1'b0; nmi = 1'b0; req = '0;
    rd(a_of(0, 3), v); check("R9 end flag on final", v & 32'h4, 32'h4);
    rd(a_of(0, 0), v); check("R9 sar updated", v, 32'h11);
    rd(GLOB, v);       check("R6 nmi flag", v, 32'h3);
    setup(3, 32'h700, 32'h800, 2, cw(1, 0, 0, 0, 1, 1));
    req[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 no grant under nmi", 32'(grant), 0);
    rd(a_of(3, 0), v); check("R6 regs held", v, 32'h700);
    wr(GLOB, 32'h3);
    rd(GLOB, v); check("R10 nmi flag sticky", v, 32'h3);
    wr(GLOB, 32'h1);
    wait_grant(3, ok);
    check("R10 resume after nmi clear", 32'(ok), 1);

    // R8: error response
    err = 1'b1; @(negedge clk); err = 1'b0; req = '0;
    rd(GLOB, v);       check("R8 address-error flag", v, 32'h5);
    rd(a_of(3, 0), v); check("R8 sar unchanged", v, 32'h700);
    rd(a_of(3, 2), v); check("R8 tcr unchanged", v, 2);
    req = 4'b1100;
    repeat (3) @(negedge clk);
    check("R8 all stopped", 32'(grant), 0);
    wr(GLOB, 32'h5);
    rd(GLOB, v); check("R10 error flag sticky", v, 32'h5);
    wr(GLOB, 32'h1);
    wait_grant(2, ok);
    check("R10 resume after error clear", 32'(grant), 32'h4);
    done = 1'b1; @(negedge clk); done = 1'b0; req = '0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule